// File: doc/BRIEF.md
# Shared-Slave Request Arbiter

This block settles which of several bus masters may drive one shared slave port of a crossbar. Every master presents a request line and a transfer-end strobe. The arbiter returns a one-hot grant vector. It also returns the index of the connected master, together with a valid flag, so that the slave-side multiplexer can be steered. A granted master keeps the slave until it signals the end of its transfer. A new decision is made only at that boundary.

Two selection schemes are available. The first is a rotating scheme. Its pointer restarts at master 0 after reset, so simultaneous first requests favour the lowest index. The second is a fixed-priority scheme that uses a per-master priority field, and ties in it go to the higher master index. A separate idle policy decides where the slave stays parked once a transfer ends. The slave can be left unconnected, kept on the last user, or moved to a configured default master. A master that is still parked on the slave and asks alone is granted in the same cycle. Any other request waits one cycle while the arbitration settles. All configuration arrives on plain input ports, one set per slave instance.

Top module: `bus_slot_arbiter`

## Requirements
- R1: While rst_n is low at a clock edge, the state clears. Afterwards `grant` is zero, `conn_valid` is 0 and the rotating pointer starts at master 0.
- R2: `grant` has at most one bit set. When a bit is set, `conn_valid` is 1 and `conn_idx` equals that bit's position.
- R3: A grant stays on the same master, whatever the requests do, until that master raises its own `xfer_end` bit. A `xfer_end` from any other master has no effect.
- R4: With `cfg_prio_mode`=0 (rotating), the search starts at the pointer and wraps modulo the number of masters. After a grant the pointer moves to the master after the one granted. With all masters requesting after reset, master 0 wins first.
- R5: With `cfg_idle_pol`=0 (park nowhere; the value 3 behaves the same), the end of a transfer clears `conn_valid`. The next request is granted one cycle after it is first presented.
- R6: With `cfg_idle_pol`=1 (park on last), the end of a transfer leaves `conn_valid`=1 and `conn_idx` unchanged. That master, requesting alone, is granted in the cycle it requests, while other masters wait one cycle.
- R7: With `cfg_idle_pol`=2 (park on default), the end of a transfer sets `conn_valid`=1 and `conn_idx`=`cfg_dflt_idx`. The default master, requesting alone, is granted at once, while other masters wait one cycle.
- R8: With `cfg_prio_mode`=1 (fixed priority), the requesting master with the largest priority value wins. The value for master i is `cfg_prio[i*PRIO_W +: PRIO_W]`.
- R9: In fixed-priority mode, requesters that tie on the largest value resolve to the highest master index.
- R10: When the parked master requests together with any other master, there is no same-cycle grant. All requests go through one cycle of arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_MASTERS | Request line per master |
| xfer_end | input | NUM_MASTERS | Last-cycle-of-transfer strobe per master |
| cfg_prio_mode | input | 1 | 0 rotating, 1 fixed priority |
| cfg_idle_pol | input | 2 | 0 park nowhere, 1 park on last, 2 park on default |
| cfg_prio | input | NUM_MASTERS*PRIO_W | Priority value per master |
| cfg_dflt_idx | input | $clog2(NUM_MASTERS) | Default master for policy 2 |
| grant | output | NUM_MASTERS | One-hot grant |
| conn_idx | output | $clog2(NUM_MASTERS) | Master steering the slave multiplexer |
| conn_valid | output | 1 | Slave is connected to `conn_idx` |

## Verification
The embedded properties check several things on every cycle. They check the one-hot form of the grant and its agreement with the connection index. They check that a grant is held until its own transfer-end. They check where the connection parks under each of the three idle policies. The bench scenarios are needed for the ordering questions: which master wins under rotation and under priorities with ties, and whether a grant arrives in the request cycle or one cycle later. They also cover the reset state and the case where the parked master competes with others.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
    typedef enum logic [1:0] {
        PARK_NONE  = 2'd0,
        PARK_LAST  = 2'd1,
        PARK_DFLT  = 2'd2,
        PARK_RSVD  = 2'd3
    } park_pol_e;
endpackage

// File: rtl/busarb_rr_pick.sv
module busarb_rr_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(start) + k;
            if (j >= N) j = j - N;
            if (!found && req[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/busarb_prio_pick.sv
module busarb_prio_pick #(
    parameter int N  = 4,
    parameter int PW = 2,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    output logic            found,
    output logic [IW-1:0]   idx
);
    logic [PW-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        // ascending scan with >= hands ties to the higher index
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || prio[i*PW +: PW] >= best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = prio[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/bus_slot_arbiter.sv
module bus_slot_arbiter
    import busarb_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int PRIO_W      = 2,
    localparam int IW         = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_MASTERS-1:0]        req,
    input  logic [NUM_MASTERS-1:0]        xfer_end,
    input  logic                          cfg_prio_mode,
    input  logic [1:0]                    cfg_idle_pol,
    input  logic [NUM_MASTERS*PRIO_W-1:0] cfg_prio,
    input  logic [IW-1:0]                 cfg_dflt_idx,
    output logic [NUM_MASTERS-1:0]        grant,
    output logic [IW-1:0]                 conn_idx,
    output logic                          conn_valid
);
    typedef struct packed {
        logic          busy;
        logic          valid;
        logic [IW-1:0] conn;
        logic [IW-1:0] ptr;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic          rr_found, pr_found;
    logic [IW-1:0] rr_idx, pr_idx;
    logic [IW-1:0] win_idx;
    logic [NUM_MASTERS-1:0] conn_oh;
    logic          fast_d, active_d, done_d;
    park_pol_e     pol;

    function automatic logic [IW-1:0] next_idx(input logic [IW-1:0] i);
        return (int'(i) == NUM_MASTERS - 1) ? '0 : i + 1'b1;
    endfunction

    busarb_rr_pick #(.N(NUM_MASTERS), .IW(IW)) u_rr (
        .req   (req),
        .start (st_q.ptr),
        .found (rr_found),
        .idx   (rr_idx)
    );

    busarb_prio_pick #(.N(NUM_MASTERS), .PW(PRIO_W), .IW(IW)) u_prio (
        .req   (req),
        .prio  (cfg_prio),
        .found (pr_found),
        .idx   (pr_idx)
    );

    always_comb begin
        pol      = park_pol_e'(cfg_idle_pol);
        win_idx  = cfg_prio_mode ? pr_idx : rr_idx;
        conn_oh  = '0;
        conn_oh[st_q.conn] = 1'b1;
        // parked master asking alone gets the slave without a settle cycle
        fast_d   = !st_q.busy && st_q.valid && req[st_q.conn]
                   && ((req & ~conn_oh) == '0);
        active_d = st_q.busy || fast_d;
        done_d   = active_d && xfer_end[st_q.conn];
        grant    = active_d ? conn_oh : '0;

        st_d = st_q;
        if (fast_d) begin
            st_d.busy = 1'b1;
            st_d.ptr  = next_idx(st_q.conn);
        end else if (!st_q.busy && (rr_found || pr_found)) begin
            st_d.busy  = 1'b1;
            st_d.valid = 1'b1;
            st_d.conn  = win_idx;
            st_d.ptr   = next_idx(win_idx);
        end
        if (done_d) begin
            st_d.busy = 1'b0;
            unique case (pol)
                PARK_LAST: st_d.valid = 1'b1;
                PARK_DFLT: begin
                    st_d.valid = 1'b1;
                    st_d.conn  = cfg_dflt_idx;
                end
                default:   st_d.valid = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign conn_idx   = st_q.conn;
    assign conn_valid = st_q.valid;

    // ---------------- assertions ----------------
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (grant == '0 && !conn_valid));

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_grant_matches_conn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> (conn_valid && grant[conn_idx]));

    assert_grant_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant) && !(|(grant & xfer_end))) |=> (grant == $past(grant)));

    assert_park_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(grant & xfer_end)) && (cfg_idle_pol == 2'd0)) |=> !conn_valid);

    assert_park_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(grant & xfer_end)) && (cfg_idle_pol == 2'd1))
        |=> (conn_valid && conn_idx == $past(conn_idx)));

    assert_park_dflt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(grant & xfer_end)) && (cfg_idle_pol == 2'd2))
        |=> (conn_valid && conn_idx == $past(cfg_dflt_idx)));
endmodule

// File: tb/tb_bus_slot_arbiter.sv
module tb_bus_slot_arbiter;
    localparam int N  = 4;
    localparam int PW = 2;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  xfer_end = '0;
    logic          cfg_prio_mode = 1'b0;
    logic [1:0]    cfg_idle_pol = 2'd0;
    logic [N*PW-1:0] cfg_prio = '0;
    logic [IW-1:0] cfg_dflt_idx = '0;
    logic [N-1:0]  grant;
    logic [IW-1:0] conn_idx;
    logic          conn_valid;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    bus_slot_arbiter #(.NUM_MASTERS(N), .PRIO_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .xfer_end(xfer_end),
        .cfg_prio_mode(cfg_prio_mode), .cfg_idle_pol(cfg_idle_pol),
        .cfg_prio(cfg_prio), .cfg_dflt_idx(cfg_dflt_idx),
        .grant(grant), .conn_idx(conn_idx), .conn_valid(conn_valid)
    );

    // rotating mode, park nowhere: {req, xfer_end, expected grant, expected valid}
    localparam logic [12:0] VEC [15] = '{
        13'b1111_0000_0000_0, 13'b1111_0000_0001_1, 13'b1111_0001_0001_1,
        13'b1110_0000_0000_0, 13'b1110_0010_0010_1, 13'b1101_0000_0000_0,
        13'b1101_0100_0100_1, 13'b0001_0000_0000_0, 13'b0001_0001_0001_1,
        13'b0000_0000_0000_0, 13'b1000_0000_0000_0, 13'b0000_0000_1000_1,
        13'b0000_0100_1000_1, 13'b0000_1000_1000_1, 13'b0000_0000_0000_0
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [N-1:0] r, input logic [N-1:0] x,
                       input logic [N-1:0] eg, input string tag);
        @(negedge clk);
        req = r;
        xfer_end = x;
        #1;
        chk(tag, int'(grant), int'(eg));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req = '0;
        xfer_end = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 grant after reset", int'(grant), 0);
        chk("R1 valid after reset", int'(conn_valid), 0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        do_reset();

        // R4 R5 R3 R2: table walk
        for (int i = 0; i < 15; i++) begin
            cyc(VEC[i][12:9], VEC[i][8:5], VEC[i][4:1], $sformatf("R4/R5/R3 row %0d grant", i));
            chk($sformatf("R2/R5 row %0d valid", i), int'(conn_valid), int'(VEC[i][0]));
        end

        // R6 and R10: park on last
        do_reset();
        cfg_idle_pol = 2'd1;
        cyc(4'b0100, 4'b0000, 4'b0000, "R6 first access latency");
        cyc(4'b0100, 4'b0100, 4'b0100, "R6 grant m2");
        cyc(4'b0000, 4'b0000, 4'b0000, "R6 idle no grant");
        chk("R6 stays valid", int'(conn_valid), 1);
        chk("R6 stays on m2", int'(conn_idx), 2);
        cyc(4'b0100, 4'b0100, 4'b0100, "R6 parked master zero latency");
        cyc(4'b0001, 4'b0000, 4'b0000, "R6 other master waits");
        cyc(4'b0001, 4'b0001, 4'b0001, "R6 other master granted");
        cyc(4'b0101, 4'b0000, 4'b0000, "R10 parked master with rival waits");
        cyc(4'b0101, 4'b0100, 4'b0100, "R10 rotation picks m2");
        chk("R2 conn idx m2", int'(conn_idx), 2);

        // R7: park on default
        do_reset();
        cfg_idle_pol = 2'd2;
        cfg_dflt_idx = 2'd3;
        cyc(4'b0010, 4'b0000, 4'b0000, "R7 m1 waits");
        cyc(4'b0010, 4'b0010, 4'b0010, "R7 m1 granted");
        cyc(4'b0000, 4'b0000, 4'b0000, "R7 idle");
        chk("R7 parked valid", int'(conn_valid), 1);
        chk("R7 parked on default", int'(conn_idx), 3);
        cyc(4'b1000, 4'b1000, 4'b1000, "R7 default zero latency");
        cyc(4'b0001, 4'b0000, 4'b0000, "R7 m0 waits");
        cyc(4'b0001, 4'b0001, 4'b0001, "R7 m0 granted");

        // R8 R9: fixed priority
        do_reset();
        cfg_idle_pol = 2'd0;
        cfg_prio_mode = 1'b1;
        cfg_prio = 8'b10_00_11_01;
        cyc(4'b1111, 4'b0000, 4'b0000, "R8 settle");
        cyc(4'b1111, 4'b0010, 4'b0010, "R8 highest value m1");
        cyc(4'b1101, 4'b0000, 4'b0000, "R8 settle");
        cyc(4'b1101, 4'b1000, 4'b1000, "R8 m3 over m0 m2");
        cfg_prio = 8'b10_10_10_10;
        cyc(4'b0111, 4'b0000, 4'b0000, "R9 settle");
        cyc(4'b0111, 4'b0100, 4'b0100, "R9 tie to m2");
        cfg_prio = 8'b11_00_11_00;
        cyc(4'b1010, 4'b0000, 4'b0000, "R9 settle");
        cyc(4'b1010, 4'b1000, 4'b1000, "R9 tie to m3");

        // R1: reset in the middle of a grant
        cyc(4'b0001, 4'b0000, 4'b0000, "R1 pre settle");
        cyc(4'b0001, 4'b0000, 4'b0001, "R1 pre grant");
        do_reset();
        cfg_prio_mode = 1'b0;
        cyc(4'b1111, 4'b0000, 4'b0000, "R1 settle");
        cyc(4'b1111, 4'b0001, 4'b0001, "R1 pointer back at m0");

        finish_run();
    end
endmodule